// File: doc/BRIEF.md
# Pipelined Single-Precision Floating-Point Divider

This block divides one IEEE 754 single-precision operand by another. A request is offered by raising `en_i` with both operands present while the block is idle. The block then walks the operation through fixed phases: an operand capture phase that tests for zero and prepends the hidden one, a preparation phase that forms the quotient sign, pre-aligns the dividend significand and forms the re-biased exponent, a restoring division phase that produces one quotient bit per clock, and a final phase that normalizes, packs and publishes the result together with a 4-bit status word.

The dividend significand is made strictly smaller than the divisor significand before dividing. When it is greater than or equal, it is shifted right once and its exponent incremented. That increment can itself leave the exponent range, and it then reports overflow without dividing. Because the aligned quotient lies in [0.5, 1), one fixed left shift with an exponent decrement normalizes it. The fraction is truncated. NaN, infinity, subnormal operands and rounding are not handled: an exponent field of zero is read as a zero operand.

Status encoding: bit 0 zero result, bit 1 overflow, bit 2 underflow, bit 3 divide-by-zero. Whenever any status bit is set, the quotient word is all zeros.

Top module: `fp_div_pipe`

## Requirements
- R1: While reset is held and after its release, `quot_o` and `stat_o` are zero and `valid_o` and `busy_o` are low.
- R2: A request is accepted at a clock edge where `en_i` is high and `busy_o` is low, and `busy_o` is high from the next cycle. `en_i` and the operands are ignored while `busy_o` is high: no extra result is produced and the running result is unaffected.
- R3: `valid_o` is high for exactly one cycle, 26 clock edges after the accepting edge, and `busy_o` is low in that cycle. `quot_o` and `stat_o` change only in that cycle and hold their values until the next result.
- R4: For nonzero, in-range operands, the quotient sign is the XOR of the operand signs (bit 31), the exponent field (bits 30:23) is the true binary exponent of the quotient plus 127, and the fraction (bits 22:0) is the truncated quotient significand. For example, 1/3 gives 0x3EAAAAAA, and 1/(-3) gives 0xBEAAAAAA.
- R5: When the dividend significand is greater than or equal to the divisor significand, the dividend is pre-aligned. 6/2 gives 0x40400000, -7.5/2.5 gives 0xC0400000, and equal significands (5/5) give exactly 0x3F800000.
- R6: A divisor with a zero exponent field gives `quot_o` = 0 and `stat_o` = 4'b1000, including when the dividend is also zero.
- R7: A dividend with a zero exponent field and a nonzero divisor gives +0 (0x00000000, even for a negative zero dividend) and `stat_o` = 4'b0001.
- R8: When the packed exponent would be 255 or more, the result is 0 with `stat_o` = 4'b0010. A packed exponent of exactly 254 is still delivered normally (0x7F000000 / 0x3F400000 = 0x7F2AAAAA).
- R9: When pre-alignment raises a dividend exponent of 254 to 255, the result is 0 with `stat_o` = 4'b0010, even if the final quotient exponent would have fit (0x7F7FFFFF / 0x64000000).
- R10: When the packed exponent would be 0 or less, the result is 0 with `stat_o` = 4'b0100. A packed exponent of 1 is still delivered normally (0x01000000 / 0x3FC00000 = 0x00AAAAAA).
- R11: At most one status bit is set. Any set status bit comes with an all-zero quotient word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously |
| en_i | input | 1 | Request strobe, taken when the block is idle |
| dividend_i | input | 32 | Single-precision dividend |
| divisor_i | input | 32 | Single-precision divisor |
| quot_o | output | 32 | Packed single-precision quotient |
| stat_o | output | 4 | Status: bit0 zero, bit1 overflow, bit2 underflow, bit3 divide-by-zero |
| valid_o | output | 1 | One-cycle pulse marking a new result |
| busy_o | output | 1 | High while a request is in progress |

## Verification
Two functions can fall in the same cycle: the publication of a result (`valid_o` high) and the acceptance of the next request, because `busy_o` is already low in that cycle. The bench provokes this by raising `en_i` with new operands in the very cycle it observes `valid_o`. It then judges three things: the published value stays on `quot_o` while the second division runs, the second result arrives exactly 26 edges after its own acceptance, and that result is correct. A second collision, a zero divisor together with a zero dividend, is judged by checking that divide-by-zero alone is reported.

// File: rtl/fp_div_pkg.sv
package fp_div_pkg;

  // Control phases of one division
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_PREP  = 2'd1,
    PH_ITER  = 2'd2,
    PH_PACK  = 2'd3
  } div_phase_e;

  // Status word bit positions
  localparam int unsigned STB_ZERO = 0;
  localparam int unsigned STB_OVF  = 1;
  localparam int unsigned STB_UNF  = 2;
  localparam int unsigned STB_DBZ  = 3;
  localparam int unsigned STAT_W   = 4;

endpackage

// File: rtl/fp_div_unpack.sv
module fp_div_unpack #(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23,
  localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W,
  localparam int unsigned SIG_W  = FRAC_W + 1
) (
  input  logic [WORD_W-1:0] word_i,
  output logic              sign_o,
  output logic [EXP_W-1:0]  exp_o,
  output logic [SIG_W-1:0]  sig_o,
  output logic              zero_o
);

  always_comb begin
    sign_o = word_i[WORD_W-1];
    exp_o  = word_i[WORD_W-2 -: EXP_W];
    // hidden one prepended to the stored fraction
    sig_o  = {1'b1, word_i[FRAC_W-1:0]};
    zero_o = (exp_o == '0);
  end

endmodule

// File: rtl/fp_div_prep.sv
module fp_div_prep #(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23,
  localparam int unsigned SIG_W = FRAC_W + 1,
  localparam int unsigned REM_W = SIG_W + 2,
  localparam int unsigned XE_W  = EXP_W + 2,
  localparam int unsigned BIAS  = (1 << (EXP_W - 1)) - 1,
  localparam int unsigned EMAX  = (1 << EXP_W) - 1
) (
  input  logic                   sign_a_i,
  input  logic                   sign_b_i,
  input  logic [EXP_W-1:0]       exp_a_i,
  input  logic [EXP_W-1:0]       exp_b_i,
  input  logic [SIG_W-1:0]       sig_a_i,
  input  logic [SIG_W-1:0]       sig_b_i,
  output logic                   sign_o,
  output logic [REM_W-1:0]       rem_init_o,
  output logic [REM_W-1:0]       dvs_o,
  output logic signed [XE_W-1:0] exp_res_o,
  output logic                   aln_ovf_o
);

  logic            shift_a;
  logic [XE_W-1:0] exp_a_al;
  logic [XE_W-1:0] exp_diff;

  always_comb begin
    sign_o  = sign_a_i ^ sign_b_i;
    shift_a = (sig_a_i >= sig_b_i);
    // Divisor scaled by two. The dividend is kept at its own scale when it
    // must be pre-shifted right, so it always ends strictly below the divisor.
    dvs_o      = {1'b0, sig_b_i, 1'b0};
    rem_init_o = shift_a ? {2'b00, sig_a_i} : {1'b0, sig_a_i, 1'b0};
    exp_a_al   = {2'b00, exp_a_i} + XE_W'(shift_a);
    aln_ovf_o  = shift_a && (exp_a_al >= XE_W'(EMAX));
    // re-bias, and subtract one for the fixed left-normalize step
    exp_diff   = exp_a_al - {2'b00, exp_b_i} + XE_W'(BIAS - 1);
    exp_res_o  = $signed(exp_diff);
  end

endmodule

// File: rtl/fp_div_step.sv
module fp_div_step #(
  parameter int unsigned REM_W = 26
) (
  input  logic [REM_W-1:0] rem_i,
  input  logic [REM_W-1:0] dvs_i,
  output logic [REM_W-1:0] rem_o,
  output logic             qbit_o
);

  logic [REM_W-1:0] shifted;
  logic [REM_W:0]   trial;

  always_comb begin
    shifted = {rem_i[REM_W-2:0], 1'b0};
    trial   = {1'b0, shifted} - {1'b0, dvs_i};
    // a non-negative trial difference means this quotient bit is one
    qbit_o  = ~trial[REM_W];
    rem_o   = qbit_o ? trial[REM_W-1:0] : shifted;
  end

endmodule

// File: rtl/fp_div_pack.sv
module fp_div_pack
  import fp_div_pkg::*;
#(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23,
  localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W,
  localparam int unsigned SIG_W  = FRAC_W + 1,
  localparam int unsigned XE_W   = EXP_W + 2,
  localparam int unsigned EMAX   = (1 << EXP_W) - 1
) (
  input  logic                   sign_i,
  input  logic signed [XE_W-1:0] exp_res_i,
  input  logic [SIG_W-1:0]       quo_i,
  input  logic                   dbz_i,
  input  logic                   zero_i,
  input  logic                   aln_ovf_i,
  output logic [WORD_W-1:0]      word_o,
  output logic [STAT_W-1:0]      stat_o
);

  localparam logic signed [XE_W-1:0] EMAX_S = XE_W'(EMAX);

  always_comb begin
    word_o = '0;
    stat_o = '0;
    if (dbz_i) begin
      stat_o[STB_DBZ] = 1'b1;
    end else if (zero_i) begin
      stat_o[STB_ZERO] = 1'b1;
    end else if (aln_ovf_i || (exp_res_i >= EMAX_S)) begin
      stat_o[STB_OVF] = 1'b1;
    end else if (exp_res_i <= $signed(XE_W'(0))) begin
      stat_o[STB_UNF] = 1'b1;
    end else begin
      // quotient MSB is the leading one after the fixed normalize step
      word_o = {sign_i, exp_res_i[EXP_W-1:0], quo_i[FRAC_W-1:0]};
    end
  end

endmodule

// File: rtl/fp_div_pipe.sv
module fp_div_pipe
  import fp_div_pkg::*;
#(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23,
  localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W,
  localparam int unsigned SIG_W  = FRAC_W + 1,
  localparam int unsigned REM_W  = SIG_W + 2,
  localparam int unsigned XE_W   = EXP_W + 2,
  localparam int unsigned CNT_W  = $clog2(SIG_W)
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              en_i,
  input  logic [WORD_W-1:0] dividend_i,
  input  logic [WORD_W-1:0] divisor_i,
  output logic [WORD_W-1:0] quot_o,
  output logic [STAT_W-1:0] stat_o,
  output logic              valid_o,
  output logic              busy_o
);

  // capture stage: zero check and unpack
  logic             up_sa, up_sb, up_za, up_zb;
  logic [EXP_W-1:0] up_ea, up_eb;
  logic [SIG_W-1:0] up_ma, up_mb;

  fp_div_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) unpack_a_i (
    .word_i(dividend_i), .sign_o(up_sa), .exp_o(up_ea), .sig_o(up_ma), .zero_o(up_za)
  );
  fp_div_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) unpack_b_i (
    .word_i(divisor_i), .sign_o(up_sb), .exp_o(up_eb), .sig_o(up_mb), .zero_o(up_zb)
  );

  div_phase_e       ph_q, ph_d;
  logic             cap_sa_q, cap_sb_q, cap_za_q, cap_zb_q;
  logic [EXP_W-1:0] cap_ea_q, cap_eb_q;
  logic [SIG_W-1:0] cap_ma_q, cap_mb_q;

  // preparation stage outputs
  logic                   pr_sign, pr_aovf;
  logic [REM_W-1:0]       pr_rem, pr_dvs;
  logic signed [XE_W-1:0] pr_exp;

  fp_div_prep #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) prep_i (
    .sign_a_i(cap_sa_q), .sign_b_i(cap_sb_q),
    .exp_a_i(cap_ea_q),  .exp_b_i(cap_eb_q),
    .sig_a_i(cap_ma_q),  .sig_b_i(cap_mb_q),
    .sign_o(pr_sign), .rem_init_o(pr_rem), .dvs_o(pr_dvs),
    .exp_res_o(pr_exp), .aln_ovf_o(pr_aovf)
  );

  logic                   sgn_q, dbz_q, zro_q, aovf_q;
  logic signed [XE_W-1:0] exp_q;
  logic [REM_W-1:0]       rem_q, dvs_q;
  logic [SIG_W-1:0]       quo_q;
  logic [CNT_W-1:0]       cnt_q;

  // iteration step
  logic [REM_W-1:0] st_rem;
  logic             st_bit;
  logic             run_div;

  fp_div_step #(.REM_W(REM_W)) step_i (
    .rem_i(rem_q), .dvs_i(dvs_q), .rem_o(st_rem), .qbit_o(st_bit)
  );

  // pack stage
  logic [WORD_W-1:0] pk_word;
  logic [STAT_W-1:0] pk_stat;

  fp_div_pack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) pack_i (
    .sign_i(sgn_q), .exp_res_i(exp_q), .quo_i(quo_q),
    .dbz_i(dbz_q), .zero_i(zro_q), .aln_ovf_i(aovf_q),
    .word_o(pk_word), .stat_o(pk_stat)
  );

  // clock enables per register group
  logic ce_cap, ce_prep, ce_iter, ce_out;
  logic iter_last;

  always_comb begin
    ce_cap    = (ph_q == PH_IDLE) && en_i;
    ce_prep   = (ph_q == PH_PREP);
    run_div   = !(dbz_q || zro_q || aovf_q);
    ce_iter   = (ph_q == PH_ITER) && run_div;
    iter_last = (cnt_q == CNT_W'(SIG_W - 1));
    ce_out    = (ph_q == PH_PACK);
    ph_d      = ph_q;
    unique case (ph_q)
      PH_IDLE: if (en_i)     ph_d = PH_PREP;
      PH_PREP:               ph_d = PH_ITER;
      PH_ITER: if (iter_last) ph_d = PH_PACK;
      PH_PACK:               ph_d = PH_IDLE;
      default:               ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      ph_q <= PH_IDLE;
    end else begin
      ph_q <= ph_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      cap_sa_q <= 1'b0; cap_sb_q <= 1'b0;
      cap_za_q <= 1'b0; cap_zb_q <= 1'b0;
      cap_ea_q <= '0;   cap_eb_q <= '0;
      cap_ma_q <= '0;   cap_mb_q <= '0;
    end else if (ce_cap) begin
      cap_sa_q <= up_sa; cap_sb_q <= up_sb;
      cap_za_q <= up_za; cap_zb_q <= up_zb;
      cap_ea_q <= up_ea; cap_eb_q <= up_eb;
      cap_ma_q <= up_ma; cap_mb_q <= up_mb;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sgn_q  <= 1'b0;
      dbz_q  <= 1'b0;
      zro_q  <= 1'b0;
      aovf_q <= 1'b0;
      exp_q  <= '0;
      dvs_q  <= '0;
    end else if (ce_prep) begin
      sgn_q  <= pr_sign;
      dbz_q  <= cap_zb_q;
      zro_q  <= cap_za_q && !cap_zb_q;
      aovf_q <= pr_aovf && !cap_za_q && !cap_zb_q;
      exp_q  <= pr_exp;
      dvs_q  <= pr_dvs;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      rem_q <= '0;
      quo_q <= '0;
    end else if (ce_prep) begin
      rem_q <= pr_rem;
      quo_q <= '0;
    end else if (ce_iter) begin
      rem_q <= st_rem;
      quo_q <= {quo_q[SIG_W-2:0], st_bit};
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      cnt_q <= '0;
    end else if (ce_prep) begin
      cnt_q <= '0;
    end else if (ph_q == PH_ITER) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      quot_o  <= '0;
      stat_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= ce_out;
      if (ce_out) begin
        quot_o <= pk_word;
        stat_o <= pk_stat;
      end
    end
  end

  assign busy_o = (ph_q != PH_IDLE);

endmodule

// File: rtl/fp_div_pipe_chk.sv
module fp_div_pipe_chk #(
  parameter int unsigned FRAC_W = 23,
  localparam int unsigned LAT   = FRAC_W + 3,
  localparam int unsigned LCW   = $clog2(LAT + 1)
) (
  input logic        clk_i,
  input logic        rst_n_i,
  input logic        en_i,
  input logic [31:0] quot_o,
  input logic [3:0]  stat_o,
  input logic        valid_o,
  input logic        busy_o
);

  logic [LCW-1:0] lat_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      lat_q <= '0;
    end else if (en_i && !busy_o) begin
      lat_q <= LCW'(1);
    end else if ((lat_q != '0) && (lat_q < LCW'(LAT))) begin
      lat_q <= lat_q + LCW'(1);
    end
  end

  // R2
  accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (en_i && !busy_o) |=> busy_o);

  // R3
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    valid_o |=> !valid_o);

  // R3
  valid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    valid_o |-> !busy_o);

  // R3
  valid_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    valid_o |-> (lat_q == LCW'(LAT)));

  // R3
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !valid_o |-> ($stable(quot_o) && $stable(stat_o)));

  // R11
  stat_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $onehot0(stat_o));

  // R11
  stat_zero_word_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (stat_o != 4'b0000) |-> (quot_o == 32'h0));

endmodule

bind fp_div_pipe fp_div_pipe_chk chk_i (
  .clk_i(clk_i), .rst_n_i(rst_n_i), .en_i(en_i), .quot_o(quot_o),
  .stat_o(stat_o), .valid_o(valid_o), .busy_o(busy_o)
);

// File: tb/fp_div_pipe_tb_top.sv
module fp_div_pipe_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int LATENCY    = 26;
  localparam int WD_LIMIT   = 100000;

  logic        clk_i = 1'b0;
  logic        rst_n_i;
  logic        en_i;
  logic [31:0] dividend_i, divisor_i;
  logic [31:0] quot_o;
  logic [3:0]  stat_o;
  logic        valid_o, busy_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  fp_div_pipe dut_i (
    .clk_i(clk_i), .rst_n_i(rst_n_i), .en_i(en_i),
    .dividend_i(dividend_i), .divisor_i(divisor_i),
    .quot_o(quot_o), .stat_o(stat_o), .valid_o(valid_o), .busy_o(busy_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > WD_LIMIT) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected below %0d", cyc, WD_LIMIT);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // drive one request at a negedge, return after it is taken
  task automatic drive(input logic [31:0] a, input logic [31:0] b);
    en_i = 1'b1; dividend_i = a; divisor_i = b;
    @(negedge clk_i);
    en_i = 1'b0;
  endtask

  // counts negedges after the accepting edge until valid_o is seen
  task automatic wait_result(output int n);
    n = 0;
    while (!valid_o && n < 200) begin
      @(negedge clk_i);
      n++;
    end
  endtask

  task automatic run_op(input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] eq, input logic [3:0] es,
                        input string req);
    int n;
    while (busy_o) @(negedge clk_i);
    drive(a, b);
    wait_result(n);
    check(n == LATENCY, "R3", {req, " latency"}, 32'(n), 32'(LATENCY));
    check(quot_o === eq, req, "quotient", quot_o, eq);
    check(stat_o === es, req, "status", 32'(stat_o), 32'(es));
  endtask

  task automatic t_reset();
    rst_n_i = 1'b0; en_i = 1'b0; dividend_i = '0; divisor_i = '0;
    repeat (3) @(negedge clk_i);
    check(quot_o === 32'h0 && stat_o === 4'h0, "R1", "outputs in reset",
          {quot_o[27:0], stat_o}, 32'h0);
    rst_n_i = 1'b1;
    repeat (2) @(negedge clk_i);
    check(!valid_o && !busy_o && quot_o === 32'h0, "R1", "after release",
          {30'h0, valid_o, busy_o}, 32'h0);
  endtask

  task automatic t_normal();
    run_op(32'h3F800000, 32'h40400000, 32'h3EAAAAAA, 4'h0, "R4 1/3");
    run_op(32'h3F800000, 32'hC0400000, 32'hBEAAAAAA, 4'h0, "R4 1/-3");
    run_op(32'hC0F00000, 32'h40200000, 32'hC0400000, 4'h0, "R5 -7.5/2.5");
    run_op(32'h40A00000, 32'h40A00000, 32'h3F800000, 4'h0, "R5 5/5");
  endtask

  // R2: requests offered while busy are dropped
  task automatic t_busy_ignore();
    int n;
    while (busy_o) @(negedge clk_i);
    drive(32'h40C00000, 32'h40000000);
    n = 0;
    for (int i = 0; i < 6; i++) begin
      check(busy_o === 1'b1, "R2", "busy after accept", 32'(busy_o), 32'h1);
      en_i = 1'b1; dividend_i = 32'h3F800000; divisor_i = 32'h40400000;
      @(negedge clk_i);
      n++;
    end
    en_i = 1'b0;
    while (!valid_o && n < 200) begin
      @(negedge clk_i);
      n++;
    end
    check(n == LATENCY, "R3", "latency with busy requests", 32'(n), 32'(LATENCY));
    check(quot_o === 32'h40400000, "R2 R5", "6/2 kept", quot_o, 32'h40400000);
    n = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_i);
      if (valid_o) n++;
    end
    check(n == 0, "R2", "no extra result", 32'(n), 32'h0);
  endtask

  // R3: accept in the publish cycle, hold the published word meanwhile
  task automatic t_back_to_back();
    int n;
    run_op(32'h40A00000, 32'h40A00000, 32'h3F800000, 4'h0, "R5 first of pair");
    drive(32'h3F800000, 32'h40400000);
    repeat (10) @(negedge clk_i);
    check(quot_o === 32'h3F800000 && !valid_o, "R3", "hold during next",
          quot_o, 32'h3F800000);
    n = 10;
    while (!valid_o && n < 200) begin
      @(negedge clk_i);
      n++;
    end
    check(n == LATENCY, "R3", "back-to-back latency", 32'(n), 32'(LATENCY));
    check(quot_o === 32'h3EAAAAAA, "R4", "second of pair", quot_o, 32'h3EAAAAAA);
  endtask

  task automatic t_special();
    run_op(32'h40000000, 32'h00000000, 32'h0, 4'b1000, "R6 x/0");
    run_op(32'h00000000, 32'h00000000, 32'h0, 4'b1000, "R6 R11 0/0");
    run_op(32'h80000000, 32'h40000000, 32'h0, 4'b0001, "R7 -0/2");
    run_op(32'h7F000000, 32'h3E400000, 32'h0, 4'b0010, "R8 overflow");
    run_op(32'h7F000000, 32'h3F400000, 32'h7F2AAAAA, 4'h0, "R8 top exponent");
    run_op(32'h7F7FFFFF, 32'h64000000, 32'h0, 4'b0010, "R9 align overflow");
    run_op(32'h00800000, 32'h3FC00000, 32'h0, 4'b0100, "R10 underflow");
    run_op(32'h01000000, 32'h3FC00000, 32'h00AAAAAA, 4'h0, "R10 bottom exponent");
  endtask

  initial begin
    t_reset();
    t_normal();
    t_busy_ignore();
    t_back_to_back();
    t_special();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule